// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides whether a received CAN frame is kept and, if it is kept, where it goes. When the frame has been fully received, the receive path presents the frame's identifier fields, its format flags, its length code and its first three data bytes, together with a one-cycle frame-done strobe. The block compares the frame against a bank of filter slots in parallel. Each slot holds a reference identifier, a per-bit mask, an identifier-type setting, a destination FIFO index and an enable. One cycle after the strobe the block reports a hit with the winning slot number and its FIFO index, or it reports a reject.

Extended-identifier frames compare the full 29-bit identifier. Standard-identifier frames compare the 11-bit identifier. In the same slot, the 18-bit extended field is reused as a pattern for the leading data bits, and a shared compare count sets how many data bits are matched. As an option, the reserved bit of an FD base-format frame can be treated as a twelfth, least significant identifier bit. Message storage is outside this block.

Top module: `can_accept_filter`

## Requirements
- R1: `res_valid` is high in exactly the cycle after each cycle in which `frm_valid` is high. When `res_valid` is low, `res_hit` is low.
- R2: A mask bit of 1 requires the frame bit to equal the slot's reference bit. A mask bit of 0 makes that position don't-care. A slot whose `cfg_en` bit is 0 never matches.
- R3: If `cfg_mide` of a slot is 1, the slot matches only frames whose `frm_ide` equals the slot's `cfg_ide`. If `cfg_mide` is 0, the slot accepts both identifier types.
- R4: For a frame with `frm_ide`=1, the slot compares `frm_sid` against `cfg_sid[11:1]` under `cfg_msid[11:1]`, and `frm_eid` against `cfg_eid` under `cfg_meid`. No data bits are compared.
- R5: For a frame with `frm_ide`=0, the first n data bits are compared, where n is `cfg_dcnt`. These bits are taken MSB first from data byte 0 bit 7, with byte 0 at `frm_data[23:16]`, byte 1 at `[15:8]` and byte 2 at `[7:0]`. Data bit i is compared with `cfg_eid[i]` under `cfg_meid[i]`. n=0 compares no data. n=18 ends at byte 2 bit 6. Values 19 to 31 act as 18.
- R6: For a frame with `frm_ide`=0, the slot fails when n exceeds the number of data bits the frame carries. That number is 8 times `frm_dlc` for `frm_dlc` below 3, and 24 otherwise. This holds even when the mask bits are 0.
- R7: For a frame with `frm_ide`=0, `frm_fdf`=1 and `cfg_sid12_en`=1, `frm_rrs` is compared with `cfg_sid[0]` under `cfg_msid[0]`. In all other cases `cfg_sid[0]` and `cfg_msid[0]` have no effect.
- R8: When several slots match, the lowest-numbered matching slot wins. Its number is reported on `res_flt`.
- R9: On a hit, `res_fifo` equals the winning slot's `cfg_fifo`. On a reject, `res_flt` and `res_fifo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Frame-done strobe, one cycle |
| frm_sid | input | 11 | Standard identifier bits |
| frm_eid | input | 18 | Identifier extension bits |
| frm_ide | input | 1 | 1 = extended identifier frame |
| frm_fdf | input | 1 | 1 = FD format frame |
| frm_rrs | input | 1 | Reserved bit following the identifier |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 24 | Data bytes 0..2, byte 0 in the top byte |
| cfg_sid12_en | input | 1 | Use reserved bit as 12th SID bit |
| cfg_dcnt | input | 5 | Number of data bits compared on standard frames |
| cfg_en | input | NUM_FLT | Slot enables |
| cfg_ide | input | NUM_FLT | Identifier type each slot expects |
| cfg_mide | input | NUM_FLT | Enforce identifier type per slot |
| cfg_sid | input | NUM_FLT x 12 | Reference SID, bit 0 is the 12th bit |
| cfg_eid | input | NUM_FLT x 18 | Reference extension / data pattern |
| cfg_msid | input | NUM_FLT x 12 | SID masks |
| cfg_meid | input | NUM_FLT x 18 | Extension / data masks |
| cfg_fifo | input | NUM_FLT x FIFO_W | Destination FIFO per slot |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | Frame accepted |
| res_flt | output | IDX_W | Winning slot number |
| res_fifo | output | FIFO_W | Destination FIFO of winner |

## Verification
The bench targets the edges of the data window. With counts of 1 and 18, it flips the last compared bit and the first uncompared bit. A design that shifted the window by one position, or that took the data pattern LSB first, would accept the first flip or reject the second. Counts above 18 are applied to catch a design that does not clamp the count. Frames shorter than the count are applied with all data masks cleared, where a design that honoured only the masks would still accept. The twelfth SID bit is toggled on FD and classic frames and with the option on and off. Overlapping slots are then enabled and disabled one by one, so that a priority encoder that favours the highest slot, or ignores enables, reports the wrong slot number or the wrong FIFO.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int SID_W    = 11;
  localparam int SIDX_W   = 12;
  localparam int EID_W    = 18;
  localparam int DWIN_W   = 24;
  localparam int DCMP_MAX = 18;
  localparam int DCNT_W   = 5;

  // data bits the frame actually carries inside the 3-byte window
  function automatic logic [5:0] avail_bits(input logic [3:0] dlc);
    logic [5:0] r;
    if (dlc >= 4'd3) r = 6'd24;
    else             r = {dlc[1:0], 3'b000};
    return r;
  endfunction

  function automatic logic [DCNT_W-1:0] clamp_cnt(input logic [DCNT_W-1:0] c);
    return (c > DCNT_W'(DCMP_MAX)) ? DCNT_W'(DCMP_MAX) : c;
  endfunction
endpackage

// File: rtl/can_flt_slot.sv
module can_flt_slot
  import can_flt_pkg::*;
(
  input  logic              f_en,
  input  logic              f_ide,
  input  logic              f_mide,
  input  logic [SIDX_W-1:0] f_sid,
  input  logic [EID_W-1:0]  f_eid,
  input  logic [SIDX_W-1:0] m_sid,
  input  logic [EID_W-1:0]  m_eid,
  input  logic [SIDX_W-1:0] in_sid12,
  input  logic [EID_W-1:0]  in_eid,
  input  logic              in_ide,
  input  logic              in_use12,
  input  logic [EID_W-1:0]  in_dbits,
  input  logic [EID_W-1:0]  in_dsel,
  input  logic              in_dlen_ok,
  output logic              hit
);
  logic [SIDX_W-1:0] sid_mask;
  logic              ide_ok, sid_ok, eid_ok, dat_ok;

  always_comb begin
    sid_mask = {m_sid[SIDX_W-1:1], m_sid[0] & in_use12};
    ide_ok   = ~f_mide | (f_ide == in_ide);
    sid_ok   = ((in_sid12 ^ f_sid) & sid_mask) == '0;
    eid_ok   = ((in_eid ^ f_eid) & m_eid) == '0;
    dat_ok   = in_dlen_ok & (((in_dbits ^ f_eid) & m_eid & in_dsel) == '0);
    hit      = f_en & ide_ok & sid_ok & (in_ide ? eid_ok : dat_ok);
  end
endmodule

// File: rtl/can_flt_prio.sv
module can_flt_prio #(
  parameter  int N     = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_flt_pkg::*;
#(
  parameter  int NUM_FLT = 32,
  parameter  int FIFO_W  = 5,
  localparam int IDX_W   = (NUM_FLT > 1) ? $clog2(NUM_FLT) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             frm_valid,
  input  logic [SID_W-1:0]                 frm_sid,
  input  logic [EID_W-1:0]                 frm_eid,
  input  logic                             frm_ide,
  input  logic                             frm_fdf,
  input  logic                             frm_rrs,
  input  logic [3:0]                       frm_dlc,
  input  logic [DWIN_W-1:0]                frm_data,
  input  logic                             cfg_sid12_en,
  input  logic [DCNT_W-1:0]                cfg_dcnt,
  input  logic [NUM_FLT-1:0]               cfg_en,
  input  logic [NUM_FLT-1:0]               cfg_ide,
  input  logic [NUM_FLT-1:0]               cfg_mide,
  input  logic [NUM_FLT-1:0][SIDX_W-1:0]   cfg_sid,
  input  logic [NUM_FLT-1:0][EID_W-1:0]    cfg_eid,
  input  logic [NUM_FLT-1:0][SIDX_W-1:0]   cfg_msid,
  input  logic [NUM_FLT-1:0][EID_W-1:0]    cfg_meid,
  input  logic [NUM_FLT-1:0][FIFO_W-1:0]   cfg_fifo,
  output logic                             res_valid,
  output logic                             res_hit,
  output logic [IDX_W-1:0]                 res_flt,
  output logic [FIFO_W-1:0]                res_fifo
);
  // shared frame decode, computed once for all slots
  logic [SIDX_W-1:0] frm_sid12;
  logic              use12;
  logic [DCNT_W-1:0] dcnt_eff;
  logic [EID_W-1:0]  dbits, dsel;
  logic              dlen_ok;

  assign frm_sid12 = {frm_sid, frm_rrs};
  assign use12     = cfg_sid12_en & frm_fdf & ~frm_ide;
  assign dcnt_eff  = clamp_cnt(cfg_dcnt);
  assign dlen_ok   = {1'b0, dcnt_eff} <= avail_bits(frm_dlc);

  for (genvar b = 0; b < EID_W; b++) begin : g_dwin
    assign dbits[b] = frm_data[DWIN_W-1-b];
    assign dsel[b]  = DCNT_W'(b) < dcnt_eff;
  end

  logic [NUM_FLT-1:0] match_vec;

  for (genvar f = 0; f < NUM_FLT; f++) begin : g_slot
    can_flt_slot u_slot (
      .f_en       (cfg_en[f]),
      .f_ide      (cfg_ide[f]),
      .f_mide     (cfg_mide[f]),
      .f_sid      (cfg_sid[f]),
      .f_eid      (cfg_eid[f]),
      .m_sid      (cfg_msid[f]),
      .m_eid      (cfg_meid[f]),
      .in_sid12   (frm_sid12),
      .in_eid     (frm_eid),
      .in_ide     (frm_ide),
      .in_use12   (use12),
      .in_dbits   (dbits),
      .in_dsel    (dsel),
      .in_dlen_ok (dlen_ok),
      .hit        (match_vec[f])
    );
  end

  logic             win_any;
  logic [IDX_W-1:0] win_idx;

  can_flt_prio #(.N(NUM_FLT)) u_prio (
    .req (match_vec),
    .any (win_any),
    .idx (win_idx)
  );

  // next-state
  logic              nxt_valid, nxt_hit, upd;
  logic [IDX_W-1:0]  nxt_flt;
  logic [FIFO_W-1:0] nxt_fifo;

  always_comb begin
    nxt_valid = frm_valid;
    nxt_hit   = frm_valid & win_any;
    nxt_flt   = nxt_hit ? win_idx : '0;
    nxt_fifo  = nxt_hit ? cfg_fifo[win_idx] : '0;
    upd       = frm_valid | res_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_flt   <= '0;
      res_fifo  <= '0;
    end else begin
      res_valid <= nxt_valid;
      if (upd) begin
        res_hit  <= nxt_hit;
        res_flt  <= nxt_flt;
        res_fifo <= nxt_fifo;
      end
    end
  end
endmodule

// File: rtl/can_flt_chk.sv
module can_flt_chk #(
  parameter  int NUM_FLT = 32,
  parameter  int FIFO_W  = 5,
  localparam int IDX_W   = (NUM_FLT > 1) ? $clog2(NUM_FLT) : 1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           frm_valid,
  input logic [NUM_FLT-1:0]             cfg_en,
  input logic [NUM_FLT-1:0][FIFO_W-1:0] cfg_fifo,
  input logic [NUM_FLT-1:0]             match_vec,
  input logic                           res_valid,
  input logic                           res_hit,
  input logic [IDX_W-1:0]               res_flt,
  input logic [FIFO_W-1:0]              res_fifo
);
  logic [NUM_FLT-1:0]             en_q, match_q, below;
  logic [NUM_FLT-1:0][FIFO_W-1:0] fifo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      match_q <= '0;
      fifo_q  <= '0;
    end else begin
      en_q    <= cfg_en;
      match_q <= match_vec;
      fifo_q  <= cfg_fifo;
    end
  end

  always_comb begin
    below = '0;
    for (int i = 0; i < NUM_FLT; i++) below[i] = (IDX_W'(i) < res_flt);
  end

  AST_RES_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> res_valid); // R1
  AST_RES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !res_valid); // R1
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_hit); // R1
  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> en_q[res_flt]); // R2
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (match_q[res_flt] && ((match_q & below) == '0))); // R8
  AST_HIT_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit == (match_q != '0))); // R8
  AST_FIFO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_fifo == fifo_q[res_flt])); // R9
  AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_flt == '0 && res_fifo == '0)); // R9
endmodule

bind can_accept_filter can_flt_chk #(.NUM_FLT(NUM_FLT), .FIFO_W(FIFO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_valid (frm_valid),
  .cfg_en    (cfg_en),
  .cfg_fifo  (cfg_fifo),
  .match_vec (match_vec),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_flt   (res_flt),
  .res_fifo  (res_fifo)
);

// File: tb/can_accept_filter_tb_top.sv
module can_accept_filter_tb_top;
  localparam int N  = 32;
  localparam int FW = 5;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              frm_valid = 1'b0;
  logic [10:0]       frm_sid = '0;
  logic [17:0]       frm_eid = '0;
  logic              frm_ide = 1'b0, frm_fdf = 1'b0, frm_rrs = 1'b0;
  logic [3:0]        frm_dlc = '0;
  logic [23:0]       frm_data = '0;
  logic              cfg_sid12_en = 1'b0;
  logic [4:0]        cfg_dcnt = '0;
  logic [N-1:0]      cfg_en = '0, cfg_ide = '0, cfg_mide = '0;
  logic [N-1:0][11:0] cfg_sid = '0, cfg_msid = '0;
  logic [N-1:0][17:0] cfg_eid = '0, cfg_meid = '0;
  logic [N-1:0][FW-1:0] cfg_fifo = '0;
  logic              res_valid, res_hit;
  logic [IW-1:0]     res_flt;
  logic [FW-1:0]     res_fifo;

  can_accept_filter #(.NUM_FLT(N), .FIFO_W(FW)) dut_i (.*);

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";
  logic e_valid, e_hit;
  int   e_flt, e_fifo;

  // behavioural reference, evaluated at each edge
  always @(posedge clk) begin
    automatic bit found = 0;
    automatic int fl = 0, ff = 0;
    if (!rst_n) begin
      e_valid = 0; e_hit = 0; e_flt = 0; e_fifo = 0;
    end else begin
      if (frm_valid) begin
        for (int f = 0; f < N && !found; f++) begin
          automatic bit ok = cfg_en[f];
          if (cfg_mide[f] && cfg_ide[f] != frm_ide) ok = 0;
          for (int b = 0; b < 11; b++)
            if (cfg_msid[f][b+1] && frm_sid[b] != cfg_sid[f][b+1]) ok = 0;
          if (cfg_sid12_en && frm_fdf && !frm_ide && cfg_msid[f][0] && frm_rrs != cfg_sid[f][0]) ok = 0;
          if (frm_ide) begin
            for (int b = 0; b < 18; b++)
              if (cfg_meid[f][b] && frm_eid[b] != cfg_eid[f][b]) ok = 0;
          end else begin
            automatic int n = (cfg_dcnt > 18) ? 18 : cfg_dcnt;
            automatic int nb = (frm_dlc > 3) ? 3 : frm_dlc;
            if (n > nb * 8) ok = 0;
            for (int i = 0; i < n; i++)
              if (cfg_meid[f][i] && frm_data[23-i] != cfg_eid[f][i]) ok = 0;
          end
          if (ok) begin found = 1; fl = f; ff = cfg_fifo[f]; end
        end
      end
      e_valid = frm_valid; e_hit = found; e_flt = fl; e_fifo = ff;
    end
  end

  always @(negedge clk) begin
    total++;
    if (res_valid !== e_valid || res_hit !== e_hit || int'(res_flt) != e_flt || int'(res_fifo) != e_fifo) begin
      bad++;
      $display("FAIL %s cyc=%0d actual v=%0b h=%0b flt=%0d fifo=%0d expected v=%0b h=%0b flt=%0d fifo=%0d",
               cur_req, cyc, res_valid, res_hit, res_flt, res_fifo, e_valid, e_hit, e_flt, e_fifo);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send(input logic [10:0] s, input logic [17:0] e, input logic ide, input logic fdf,
                      input logic rrs, input logic [3:0] dlc, input logic [23:0] d);
    frm_sid = s; frm_eid = e; frm_ide = ide; frm_fdf = fdf; frm_rrs = rrs;
    frm_dlc = dlc; frm_data = d; frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic clr_cfg();
    cfg_en = '0; cfg_ide = '0; cfg_mide = '0; cfg_sid = '0; cfg_msid = '0;
    cfg_eid = '0; cfg_meid = '0; cfg_fifo = '0; cfg_dcnt = '0; cfg_sid12_en = 1'b0;
  endtask

  task automatic set_slot(input int f, input logic [11:0] s, input logic [11:0] ms, input logic [17:0] e,
                          input logic [17:0] me, input logic ide, input logic mide, input int fifo);
    cfg_en[f] = 1'b1; cfg_sid[f] = s; cfg_msid[f] = ms; cfg_eid[f] = e; cfg_meid[f] = me;
    cfg_ide[f] = ide; cfg_mide[f] = mide; cfg_fifo[f] = FW'(fifo);
  endtask

  localparam logic [23:0] PAT = 24'hB5_6E_C9;

  function automatic logic [17:0] pat_eid(input logic [23:0] d);
    logic [17:0] r;
    for (int i = 0; i < 18; i++) r[i] = d[23-i];
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1"; // reset state held
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    cur_req = "R2"; // nothing enabled, masks wide open
    clr_cfg();
    cfg_meid[4] = '1; cfg_msid[4] = '1;
    send(11'h123, 18'h0, 0, 0, 0, 4'd8, 24'h0);
    set_slot(5, {11'h123, 1'b0}, 12'hFFE, 18'h0, 18'h0, 0, 1, 9);
    send(11'h123, 18'h0, 0, 0, 0, 4'd8, 24'h0);
    send(11'h122, 18'h0, 0, 0, 0, 4'd8, 24'h0);
    cfg_msid[5] = 12'hFFC;   // bit0 of SID don't-care
    send(11'h122, 18'h0, 0, 0, 0, 4'd8, 24'h0);
    cfg_en[5] = 1'b0;
    send(11'h123, 18'h0, 0, 0, 0, 4'd8, 24'h0);

    cur_req = "R3";
    clr_cfg();
    set_slot(2, {11'h055, 1'b0}, 12'hFFE, 18'h2AAAA, 18'h3FFFF, 1, 1, 3);
    send(11'h055, 18'h2AAAA, 0, 0, 0, 4'd8, 24'h0);
    send(11'h055, 18'h2AAAA, 1, 0, 0, 4'd8, 24'h0);
    cfg_mide[2] = 1'b0; cfg_meid[2] = '0;
    send(11'h055, 18'h0, 0, 0, 0, 4'd8, 24'h0);

    cur_req = "R4";
    cfg_mide[2] = 1'b1; cfg_meid[2] = '1; cfg_dcnt = 5'd18;
    send(11'h055, 18'h2AAAA, 1, 1, 0, 4'd0, 24'hFFFFFF);
    send(11'h055, 18'h2AAAB, 1, 0, 0, 4'd8, 24'h0);
    send(11'h455, 18'h2AAAA, 1, 0, 0, 4'd8, 24'h0);

    cur_req = "R5";
    clr_cfg();
    set_slot(0, {11'h3A1, 1'b0}, 12'hFFE, pat_eid(PAT), 18'h3FFFF, 0, 1, 17);
    cfg_dcnt = 5'd18;
    send(11'h3A1, 18'h0, 0, 0, 0, 4'd8, PAT);
    send(11'h3A1, 18'h0, 0, 0, 0, 4'd8, PAT ^ 24'h000040);
    send(11'h3A1, 18'h0, 0, 0, 0, 4'd8, PAT ^ 24'h000020);
    cfg_dcnt = 5'd1;
    send(11'h3A1, 18'h0, 0, 0, 0, 4'd8, PAT ^ 24'h800000);
    send(11'h3A1, 18'h0, 0, 0, 0, 4'd8, PAT ^ 24'h400000);
    cfg_dcnt = 5'd0;
    send(11'h3A1, 18'h0, 0, 0, 0, 4'd8, ~PAT);
    cfg_dcnt = 5'd25;
    send(11'h3A1, 18'h0, 0, 0, 0, 4'd8, PAT ^ 24'h000040);
    send(11'h3A1, 18'h0, 0, 0, 0, 4'd8, PAT ^ 24'h00001F);
    cfg_dcnt = 5'd31;
    send(11'h3A1, 18'h0, 0, 1, 0, 4'd15, PAT);

    cur_req = "R6";
    cfg_meid[0] = '0; cfg_dcnt = 5'd9;
    send(11'h3A1, 18'h0, 0, 0, 0, 4'd1, PAT);
    send(11'h3A1, 18'h0, 0, 0, 0, 4'd2, PAT);
    cfg_dcnt = 5'd0;
    send(11'h3A1, 18'h0, 0, 0, 0, 4'd0, PAT);
    cfg_dcnt = 5'd17;
    send(11'h3A1, 18'h0, 0, 0, 0, 4'd2, PAT);
    send(11'h3A1, 18'h0, 0, 0, 0, 4'd3, PAT);

    cur_req = "R7";
    clr_cfg();
    set_slot(6, {11'h7F0, 1'b1}, 12'hFFF, 18'h0, 18'h0, 0, 1, 30);
    cfg_sid12_en = 1'b1;
    send(11'h7F0, 18'h0, 0, 1, 1, 4'd8, 24'h0);
    send(11'h7F0, 18'h0, 0, 1, 0, 4'd8, 24'h0);
    send(11'h7F0, 18'h0, 0, 0, 0, 4'd8, 24'h0);
    cfg_sid12_en = 1'b0;
    send(11'h7F0, 18'h0, 0, 1, 0, 4'd8, 24'h0);
    cfg_sid12_en = 1'b1; cfg_msid[6] = 12'hFFE;
    send(11'h7F0, 18'h0, 0, 1, 0, 4'd8, 24'h0);

    cur_req = "R8";
    clr_cfg();
    for (int f = 3; f < N; f += 4) set_slot(f, 12'h0, 12'h0, 18'h0, 18'h0, 0, 0, (f * 7) % 32);
    send(11'h2, 18'h0, 0, 0, 0, 4'd8, 24'h0);
    for (int f = 3; f < N; f += 4) begin
      cfg_en[f] = 1'b0;
      send(11'h2, 18'h1, 1, 0, 0, 4'd8, 24'h0);
    end
    set_slot(N - 1, 12'h0, 12'h0, 18'h0, 18'h0, 0, 0, 21);
    set_slot(0, 12'h0, 12'h0, 18'h0, 18'h0, 0, 0, 11);
    send(11'h7FF, 18'h0, 0, 0, 0, 4'd8, 24'h0);

    cur_req = "R9";
    for (int k = 0; k < 400; k++) begin
      automatic int pick = $urandom_range(N - 1);
      clr_cfg();
      cfg_dcnt = 5'($urandom);
      cfg_sid12_en = 1'($urandom);
      for (int f = 0; f < N; f++) begin
        cfg_en[f] = ($urandom_range(3) == 0); cfg_ide[f] = 1'($urandom); cfg_mide[f] = 1'($urandom);
        cfg_sid[f] = 12'($urandom); cfg_eid[f] = 18'($urandom);
        cfg_msid[f] = 12'($urandom) | 12'($urandom); cfg_meid[f] = 18'($urandom) | 18'($urandom);
        cfg_fifo[f] = FW'($urandom);
      end
      if ($urandom_range(1) == 1) begin
        automatic logic [23:0] d = 24'($urandom);
        for (int i = 0; i < 18; i++) d[23-i] = cfg_eid[pick][i];
        send(cfg_sid[pick][11:1], cfg_eid[pick], cfg_ide[pick], 1'($urandom), cfg_sid[pick][0],
             4'($urandom), d);
      end else begin
        send(11'($urandom), 18'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), 24'($urandom));
      end
    end

    cur_req = "R1"; // back-to-back strobes
    frm_valid = 1'b1; frm_ide = 1'b0; frm_dlc = 4'd8;
    repeat (4) @(negedge clk);
    frm_valid = 1'b0;
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule